// File: doc/BRIEF.md
# Repair Fuse Chain Hardening Controller

This controller makes soft repair permanent. On an unload request it walks the serial fuse register chain that threads through every memory wrapper. It feeds each bit back into the chain while it reads it, so the chain ends the operation unchanged. Whenever a memory's segment shows its repair-enable bit set, the controller emits a record into a bit stream. A record is the memory's index followed by the segment. The stream is packed into fuse ROM words and written through a word-wide port. Memories that needed no repair cost no ROM space. A header word at address 0 is written last. It marks the image valid and gives the record count.

On a load request, for example after power-up, the controller reads the header and then fetches data words as it needs them. It rebuilds the whole chain by shifting in either a stored segment or a run of zeros for each memory, in chain order. After exactly one chain length of shifts, every segment sits in its own wrapper. A ROM image that would not fit aborts the hardening. No header is written and an error flag is raised, while the chain still recirculates fully.

Top module: `fuse_hardener`

## Requirements
- R1: After reset, done, err, chain_shift, rom_we and rom_re are all 0.
- R2: The chain bit order is fixed. Memory 0's segment leaves chain_so first, each segment most significant bit first, and memory index rises. An unload asserts chain_shift for exactly the total chain length, with chain_si equal to chain_so, so the chain contents are unchanged at the end.
- R3: A segment whose most significant bit is 1 produces one record: the memory index (ceil(log2 NUM_MEM) bits, MSB first) followed by the segment, MSB first. Records appear in rising memory order. A segment whose MSB is 0 produces nothing.
- R4: The record stream is packed into W-bit words, the first stream bit in bit W-1. The words are written to addresses 1, 2, 3 and onward. A final partial word is padded with zeros in its low bits.
- R5: After all data words, the controller writes the header to address 0 as its last write. The header has bit W-1 set, the record count in the low bits, and 0 in all other bits. done rises in the next cycle.
- R6: A data word whose address would be DEPTH or more is not written. After such a word, no further data words and no header are written. err is 1 together with done, while the chain still gets its full recirculation.
- R7: A load reads the header. When bit W-1 is 1, the controller asserts chain_shift exactly total-length times. Memories that have a record receive their stored segment, and all other memories receive zeros, so unload followed by load restores every repaired segment exactly. err is 0 after a load.
- R8: A header with bit W-1 clear makes the load shift zeros into the whole chain after a single ROM read.
- R9: done is a one-cycle pulse at the end of each operation. Start requests that arrive while an operation runs are ignored.
- R10: An unload with no repaired memory writes only the header, holding a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unload_start | input | 1 | Request: harden the chain contents into the ROM |
| load_start | input | 1 | Request: rebuild the chain from the ROM |
| chain_so | input | 1 | Serial output of the memory fuse chain |
| chain_si | output | 1 | Serial input to the memory fuse chain |
| chain_shift | output | 1 | Shift enable for the whole chain |
| rom_addr | output | AW | ROM word address, AW = ceil(log2 DEPTH) |
| rom_we | output | 1 | ROM word write strobe |
| rom_wdata | output | W | ROM write word |
| rom_re | output | 1 | ROM read strobe; data is expected one cycle later |
| rom_rdata | input | W | ROM read word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last unload overflowed the ROM |

## Verification
A wrong segment counter or memory index inside the controller shows at the ports within one record. The written word sequence drifts from the bench's own packing of the chain, or the chain_shift count differs from the chain length by the end of the operation. A fault in the unpack path shows after load as a displaced or corrupted segment in the chain model, checked the cycle done pulses. Overflow and header faults show as an extra, missing or misplaced write at address 0 or at address DEPTH-1, which the scoreboard sees in the cycle of the write.

// File: rtl/fuse_hardener_pkg.sv
package fuse_hardener_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        U_SHIFT,
        U_EMIT,
        U_FLUSH,
        U_HDR,
        L_HDR_RD,
        L_HDR_WT,
        L_ID,
        L_SEG
    } fh_state_e;

    localparam int LEN_FIELD = 8;

endpackage

// File: rtl/fuse_word_packer.sv
module fuse_word_packer #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic          flush,
    output logic          wr,
    output logic [AW-1:0] waddr,
    output logic [W-1:0]  wdata,
    output logic          ovf
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  acc;
        logic [CW-1:0] cnt;
        logic [AW:0]   addr;
        logic          ovf;
    } pk_t;

    pk_t pk_q, pk_d;
    logic full, part, emit, room;

    always_comb begin
        pk_d  = pk_q;
        full  = bit_valid && (pk_q.cnt == CW'(W - 1));
        part  = flush && (pk_q.cnt != '0);
        emit  = full || part;
        room  = (int'(pk_q.addr) < DEPTH);
        wr    = emit && room;
        waddr = pk_q.addr[AW-1:0];
        if (full) wdata = {pk_q.acc[W-2:0], bit_in};
        else      wdata = pk_q.acc << (W - int'(pk_q.cnt));
        if (clr) begin
            pk_d.acc  = '0;
            pk_d.cnt  = '0;
            pk_d.addr = (AW+1)'(1);
            pk_d.ovf  = 1'b0;
        end else begin
            if (bit_valid) begin
                pk_d.acc = {pk_q.acc[W-2:0], bit_in};
                pk_d.cnt = full ? '0 : pk_q.cnt + 1'b1;
            end
            if (flush) begin
                pk_d.acc = '0;
                pk_d.cnt = '0;
            end
            if (emit) begin
                if (room) pk_d.addr = pk_q.addr + 1'b1;
                else      pk_d.ovf  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign ovf = pk_q.ovf;

    // R4: flushing and packing never happen in the same cycle
    a_r4_flush_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && bit_valid));

endmodule

// File: rtl/fuse_word_unpacker.sv
module fuse_word_unpacker #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          need,
    input  logic          take,
    input  logic [W-1:0]  rdata,
    output logic          rd,
    output logic [AW-1:0] raddr,
    output logic          bit_out,
    output logic          ready
);
    localparam int NB = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  word;
        logic [NB-1:0] cnt;
        logic          pend;
        logic [AW:0]   addr;
    } up_t;

    up_t up_q, up_d;

    always_comb begin
        up_d    = up_q;
        ready   = (up_q.cnt != '0);
        bit_out = up_q.word[W-1];
        rd      = need && (up_q.cnt == '0) && !up_q.pend;
        raddr   = up_q.addr[AW-1:0];
        if (clr) begin
            up_d.word = '0;
            up_d.cnt  = '0;
            up_d.pend = 1'b0;
            up_d.addr = (AW+1)'(1);
        end else begin
            if (up_q.pend) begin
                up_d.word = rdata;
                up_d.cnt  = NB'(W);
                up_d.pend = 1'b0;
            end else if (take) begin
                up_d.word = {up_q.word[W-2:0], 1'b0};
                up_d.cnt  = up_q.cnt - 1'b1;
            end
            if (rd) begin
                up_d.pend = 1'b1;
                up_d.addr = up_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= '0;
        else        up_q <= up_d;
    end

    // R7: the controller only consumes a bit that has been fetched
    a_r7_take_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ready);

endmodule

// File: rtl/fuse_hardener.sv
module fuse_hardener
    import fuse_hardener_pkg::*;
#(
    parameter int                      NUM_MEM  = 4,
    parameter logic [NUM_MEM*8-1:0]    SEG_LENS = {8'd5, 8'd8, 8'd4, 8'd6},
    parameter int                      W        = 8,
    parameter int                      DEPTH    = 4,
    parameter int                      AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unload_start,
    input  logic          load_start,
    input  logic          chain_so,
    output logic          chain_si,
    output logic          chain_shift,
    output logic [AW-1:0] rom_addr,
    output logic          rom_we,
    output logic [W-1:0]  rom_wdata,
    output logic          rom_re,
    input  logic [W-1:0]  rom_rdata,
    output logic          done,
    output logic          err
);
    function automatic int seg_len(input int m);
        return int'(SEG_LENS[m*LEN_FIELD +: LEN_FIELD]);
    endfunction

    function automatic int max_len();
        int mx = 1;
        for (int i = 0; i < NUM_MEM; i++)
            if (seg_len(i) > mx) mx = seg_len(i);
        return mx;
    endfunction

    localparam int SEG_MAX = max_len();
    localparam int IDW     = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
    localparam int CNTW    = $clog2(NUM_MEM + 1);
    localparam int IXW     = $clog2(IDW + SEG_MAX);

    typedef struct packed {
        fh_state_e          st;
        logic [IDW-1:0]     mem;
        logic [IXW-1:0]     idx;
        logic [SEG_MAX-1:0] seg;
        logic [CNTW-1:0]    recs;
        logic [IDW-1:0]     id;
        logic               id_have;
        logic               done;
        logic               err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic          pk_clr, pk_valid, pk_bit, pk_flush, pk_wr, pk_ovf;
    logic [AW-1:0] pk_addr;
    logic [W-1:0]  pk_word;
    logic          up_clr, up_need, up_take, up_rd, up_bit, up_ready;
    logic [AW-1:0] up_addr;
    logic          hdr_we, hdr_re;
    logic [W-1:0]  hdr_word;

    fuse_word_packer #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .bit_valid(pk_valid),
        .bit_in(pk_bit), .flush(pk_flush), .wr(pk_wr), .waddr(pk_addr),
        .wdata(pk_word), .ovf(pk_ovf)
    );

    fuse_word_unpacker #(.W(W), .AW(AW)) u_unpack (
        .clk(clk), .rst_n(rst_n), .clr(up_clr), .need(up_need),
        .take(up_take), .rdata(rom_rdata), .rd(up_rd), .raddr(up_addr),
        .bit_out(up_bit), .ready(up_ready)
    );

    always_comb begin
        int  len;
        int  k;
        logic match;
        logic step;
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        pk_clr      = 1'b0;
        pk_valid    = 1'b0;
        pk_bit      = 1'b0;
        pk_flush    = 1'b0;
        up_clr      = 1'b0;
        up_need     = 1'b0;
        up_take     = 1'b0;
        chain_shift = 1'b0;
        chain_si    = 1'b0;
        hdr_we      = 1'b0;
        hdr_re      = 1'b0;
        hdr_word    = '0;
        match       = 1'b0;
        step        = 1'b0;
        len         = seg_len(int'(ctl_q.mem));
        k           = int'(ctl_q.idx);
        case (ctl_q.st)
            S_IDLE: begin
                if (unload_start) begin
                    ctl_d.st   = U_SHIFT;
                    ctl_d.mem  = '0;
                    ctl_d.idx  = '0;
                    ctl_d.recs = '0;
                    ctl_d.err  = 1'b0;
                    pk_clr     = 1'b1;
                end else if (load_start) begin
                    ctl_d.st  = L_HDR_RD;
                    ctl_d.err = 1'b0;
                    up_clr    = 1'b1;
                end
            end
            U_SHIFT: begin
                chain_shift = 1'b1;
                chain_si    = chain_so;
                ctl_d.seg   = SEG_MAX'({ctl_q.seg, chain_so});
                if (k == len - 1) begin
                    ctl_d.idx = '0;
                    if (ctl_d.seg[len-1])                  ctl_d.st = U_EMIT;
                    else if (int'(ctl_q.mem) == NUM_MEM-1) ctl_d.st = U_FLUSH;
                    else                                   ctl_d.mem = ctl_q.mem + 1'b1;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            U_EMIT: begin
                pk_valid = 1'b1;
                if (k < IDW) pk_bit = ctl_q.mem[IDW-1-k];
                else         pk_bit = ctl_q.seg[len-1-(k-IDW)];
                if (k == IDW + len - 1) begin
                    ctl_d.idx  = '0;
                    ctl_d.recs = ctl_q.recs + 1'b1;
                    if (int'(ctl_q.mem) == NUM_MEM-1) begin
                        ctl_d.st = U_FLUSH;
                    end else begin
                        ctl_d.mem = ctl_q.mem + 1'b1;
                        ctl_d.st  = U_SHIFT;
                    end
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            U_FLUSH: begin
                pk_flush = 1'b1;
                ctl_d.st = U_HDR;
            end
            U_HDR: begin
                if (!pk_ovf) begin
                    hdr_we                = 1'b1;
                    hdr_word[W-1]         = 1'b1;
                    hdr_word[CNTW-1:0]    = ctl_q.recs;
                end
                ctl_d.err  = pk_ovf;
                ctl_d.done = 1'b1;
                ctl_d.st   = S_IDLE;
            end
            L_HDR_RD: begin
                hdr_re   = 1'b1;
                ctl_d.st = L_HDR_WT;
            end
            L_HDR_WT: begin
                ctl_d.mem     = '0;
                ctl_d.idx     = '0;
                ctl_d.id_have = 1'b0;
                ctl_d.recs    = rom_rdata[W-1] ? rom_rdata[CNTW-1:0] : '0;
                ctl_d.st      = (ctl_d.recs != '0) ? L_ID : L_SEG;
            end
            L_ID: begin
                up_need = 1'b1;
                if (up_ready) begin
                    up_take  = 1'b1;
                    ctl_d.id = IDW'({ctl_q.id, up_bit});
                    if (k == IDW - 1) begin
                        ctl_d.idx     = '0;
                        ctl_d.id_have = 1'b1;
                        ctl_d.st      = L_SEG;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            L_SEG: begin
                match       = ctl_q.id_have && (ctl_q.id == ctl_q.mem);
                step        = match ? up_ready : 1'b1;
                up_need     = match;
                up_take     = match && up_ready;
                chain_si    = match && up_bit;
                chain_shift = step;
                if (step) begin
                    if (k == len - 1) begin
                        ctl_d.idx = '0;
                        if (match) begin
                            ctl_d.recs    = ctl_q.recs - 1'b1;
                            ctl_d.id_have = 1'b0;
                        end
                        if (int'(ctl_q.mem) == NUM_MEM-1) begin
                            ctl_d.done = 1'b1;
                            ctl_d.st   = S_IDLE;
                        end else begin
                            ctl_d.mem = ctl_q.mem + 1'b1;
                            ctl_d.st  = (ctl_d.recs != '0 && !ctl_d.id_have) ? L_ID : L_SEG;
                        end
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rom_we    = pk_wr || hdr_we;
    assign rom_re    = hdr_re || up_rd;
    assign rom_wdata = hdr_we ? hdr_word : pk_word;
    assign rom_addr  = (hdr_we || hdr_re) ? '0 : (pk_wr ? pk_addr : up_addr);
    assign done      = ctl_q.done;
    assign err       = ctl_q.err;

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: the header write is the final act of an unload
    a_r5_header_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_we && rom_addr == '0) |=> done);
    // R7: the ROM port never reads and writes in one cycle
    a_r7_rom_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_we && rom_re));
    // R6: an overflow is reported together with completion
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

endmodule

// File: tb/fuse_hardener_test.sv
module fuse_hardener_test;
    localparam int NM    = 4;
    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int AW    = 2;
    localparam int IDW   = 2;
    localparam int TOTAL = 23;
    localparam int LEN [NM] = '{6, 4, 8, 5};
    localparam int OFF [NM] = '{0, 6, 10, 18};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic unload_start = 1'b0, load_start = 1'b0;
    logic chain_so, chain_si, chain_shift;
    logic [AW-1:0] rom_addr;
    logic rom_we, rom_re, done, err;
    logic [W-1:0] rom_wdata, rom_rdata;

    fuse_hardener uut (
        .clk(clk), .rst_n(rst_n), .unload_start(unload_start),
        .load_start(load_start), .chain_so(chain_so), .chain_si(chain_si),
        .chain_shift(chain_shift), .rom_addr(rom_addr), .rom_we(rom_we),
        .rom_wdata(rom_wdata), .rom_re(rom_re), .rom_rdata(rom_rdata),
        .done(done), .err(err)
    );

    // chain model: bit 0 is the serial output end
    logic [TOTAL-1:0] ch;
    logic ch_ld = 1'b0;
    logic [TOTAL-1:0] ch_val = '0;
    always @(posedge clk)
        if (ch_ld) ch <= ch_val;
        else if (chain_shift) ch <= {chain_si, ch[TOTAL-1:1]};
    assign chain_so = ch[0];

    // ROM model with one-cycle read latency
    logic [W-1:0] rom [DEPTH];
    logic poke_en = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [W-1:0] poke_data = '0;
    always @(posedge clk) begin
        if (poke_en) rom[poke_addr] <= poke_data;
        else if (rom_we) rom[rom_addr] <= rom_wdata;
        if (rom_re) rom_rdata <= rom[rom_addr];
    end

    typedef struct { int a; int d; } wr_t;
    wr_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int mon_chk = 0, mon_fail = 0, mon_shifts = 0, mon_reads = 0;

    // monitor: pops expected writes as the design performs them
    always @(negedge clk) begin
        if (rst_n) begin
            if (chain_shift) mon_shifts++;
            if (rom_re) mon_reads++;
            if (rom_we) begin
                mon_chk++;
                if (exp_q.size() == 0) begin
                    mon_fail++;
                    $display("FAIL R4 unexpected write: actual addr %0d data %0h expected none",
                             rom_addr, rom_wdata);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    if (e.a != int'(rom_addr) || e.d != int'(rom_wdata)) begin
                        mon_fail++;
                        $display("FAIL R4 write: actual addr %0d data %0h expected addr %0d data %0h",
                                 rom_addr, rom_wdata, e.a, e.d);
                    end
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [TOTAL-1:0] mk(input logic [7:0] s0, input logic [7:0] s1,
                                            input logic [7:0] s2, input logic [7:0] s3);
        logic [TOTAL-1:0] c;
        logic [7:0] s [NM];
        c = '0;
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        for (int m = 0; m < NM; m++)
            for (int j = 0; j < LEN[m]; j++)
                c[OFF[m]+j] = s[m][LEN[m]-1-j];
        return c;
    endfunction

    function automatic logic [7:0] seg_of(input logic [TOTAL-1:0] c, input int m);
        logic [7:0] v;
        v = '0;
        for (int j = 0; j < LEN[m]; j++) v[LEN[m]-1-j] = c[OFF[m]+j];
        return v;
    endfunction

    function automatic logic [TOTAL-1:0] kept(input logic [TOTAL-1:0] c);
        logic [7:0] s [NM];
        for (int m = 0; m < NM; m++) begin
            s[m] = seg_of(c, m);
            if (!s[m][LEN[m]-1]) s[m] = '0;
        end
        return mk(s[0], s[1], s[2], s[3]);
    endfunction

    // builds the expected write sequence; returns 1 when overflow is expected
    function automatic logic plan_unload(input logic [TOTAL-1:0] c);
        logic bq[$];
        logic [7:0] s;
        int cnt, nw;
        logic ovf;
        wr_t e;
        cnt = 0; ovf = 1'b0;
        exp_q.delete();
        for (int m = 0; m < NM; m++) begin
            s = seg_of(c, m);
            if (s[LEN[m]-1]) begin
                cnt++;
                for (int b = IDW-1; b >= 0; b--) bq.push_back(m[b]);
                for (int b = LEN[m]-1; b >= 0; b--) bq.push_back(s[b]);
            end
        end
        nw = (bq.size() + W - 1) / W;
        for (int k = 0; k < nw; k++) begin
            logic [W-1:0] wd;
            wd = '0;
            for (int b = 0; b < W; b++)
                if (k*W + b < bq.size()) wd[W-1-b] = bq[k*W+b];
            if (k + 1 < DEPTH) begin
                e.a = k + 1; e.d = int'(wd);
                exp_q.push_back(e);
            end else ovf = 1'b1;
        end
        if (!ovf) begin
            e.a = 0; e.d = 128 + cnt;
            exp_q.push_back(e);
        end
        return ovf;
    endfunction

    task automatic preload(input logic [TOTAL-1:0] c);
        @(negedge clk); ch_ld = 1'b1; ch_val = c;
        @(negedge clk); ch_ld = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        chk(done, {tag, " completion"}, 32'(done), 1);
    endtask

    task automatic run_unload(input logic [TOTAL-1:0] c, input logic inject, input string tag);
        logic eovf;
        int s0, r0;
        preload(c);
        eovf = plan_unload(c);
        s0 = mon_shifts; r0 = mon_reads;
        unload_start = 1'b1;
        @(negedge clk); unload_start = 1'b0;
        if (inject) begin
            repeat (4) @(negedge clk);
            load_start = 1'b1;
            @(negedge clk); load_start = 1'b0;
        end
        wait_done(tag);
        chk(err == eovf, {tag, " R6 err flag"}, 32'(err), 32'(eovf));
        chk(ch == c, {tag, " R2 chain preserved"}, 32'(ch), 32'(c));
        chk(mon_shifts - s0 == TOTAL, {tag, " R2 shift count"}, mon_shifts - s0, TOTAL);
        chk(exp_q.size() == 0, {tag, " R4 all expected writes seen"}, exp_q.size(), 0);
        @(negedge clk);
        chk(!done, {tag, " R9 done pulse width"}, 32'(done), 0);
        if (inject) begin
            repeat (10) @(negedge clk);
            chk(mon_shifts - s0 == TOTAL && mon_reads == r0, {tag, " R9 start ignored while busy"},
                mon_shifts - s0, TOTAL);
        end
    endtask

    task automatic run_load(input logic [TOTAL-1:0] expc, input int exp_reads, input string tag);
        int s0, r0;
        preload(23'h55_2AD3);
        s0 = mon_shifts; r0 = mon_reads;
        load_start = 1'b1;
        @(negedge clk); load_start = 1'b0;
        wait_done(tag);
        chk(ch == expc, {tag, " R7 chain rebuilt"}, 32'(ch), 32'(expc));
        chk(mon_shifts - s0 == TOTAL, {tag, " R7 shift count"}, mon_shifts - s0, TOTAL);
        chk(!err, {tag, " R7 err clear"}, 32'(err), 0);
        if (exp_reads >= 0)
            chk(mon_reads - r0 == exp_reads, {tag, " R8 single header read"}, mon_reads - r0, exp_reads);
        @(negedge clk);
    endtask

    initial begin
        logic [TOTAL-1:0] pa, pb, pz, pf;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!done && !err && !chain_shift && !rom_we && !rom_re, "R1 reset outputs",
            {27'd0, done, err, chain_shift, rom_we, rom_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R4, R5: two repaired memories, partial final word
        pa = mk(8'h2D, 8'h03, 8'h9C, 8'h00);
        pa = kept(pa);
        run_unload(pa, 1'b0, "pattern A R3 R5");
        run_load(pa, -1, "load A");

        // R10: nothing repaired, header only with count 0
        pz = '0;
        run_unload(pz, 1'b0, "empty R10");
        run_load(pz, -1, "load empty");

        // R3: unrepaired segment with nonzero bits is not stored, loads as zeros
        pb = mk(8'h1F, 8'h0B, 8'h00, 8'h11);
        run_unload(pb, 1'b0, "pattern B R3");
        run_load(kept(pb), -1, "load B R7");

        // R6 + R9: all memories repaired overflows the ROM; load request mid-run ignored
        pf = mk(8'h2D, 8'h0B, 8'h9C, 8'h11);
        run_unload(pf, 1'b1, "overflow R6");

        // R8: invalid header loads all zeros after one read
        @(negedge clk); poke_en = 1'b1; poke_addr = '0; poke_data = 8'h03;
        @(negedge clk); poke_en = 1'b0;
        run_load('0, 1, "invalid header R8");

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
        $finish;
    end

endmodule